// File: doc/BRIEF.md
# Max-Tree Round-Robin Arbiter with Merged Data Multiplexer

This block chooses one of N requesting inputs and forwards that input's data word. It does not search cyclically from a pointer. It turns every input into a 2-bit unsigned symbol and passes the symbols through a binary tree of maximum-selection nodes. The request bit is the upper bit of the symbol and a stored priority bit is the lower bit. Each node forwards the larger of its two symbols, and on a tie it forwards the right-hand one. Each node also raises a direction flag that selects the data word at the same node. The winning data word therefore reaches the root in the same pass as the arbitration result. The chain of flags from the root to a leaf spells out the binary index of the winner.

Input 0 is the rightmost leaf and higher indices lie further left. The stored priority bits form a thermometer mask that is set for every input above the last granted index. The tie rule toward the right then gives plain round-robin order. The grant is combinational in the cycle of the request, and the mask updates at the next clock edge. A lock input holds the connection across the remaining cycles of a multi-word packet.

Top module: `rrmx_arb`

## Requirements
- R1: A grant (gnt_vld_o=1) goes only to an input whose req_i bit is set, unless the block is locked. With no request and no lock, gnt_vld_o=0, gnt_oh_o=0, gnt_idx_o=0 and data_o=0.
- R2: After reset, the first grant goes to the lowest-indexed requesting input.
- R3: Input i has priority bit 1 exactly when i is greater than the last granted index. The winner is the lowest-indexed requester whose priority bit is set. If no such requester exists, the winner is the lowest-indexed requester. The result is cyclic order starting after the last winner.
- R4: gnt_idx_o is the binary index of the winner. gnt_oh_o has at most one bit set, and when a grant is issued that bit is bit gnt_idx_o.
- R5: In the same cycle as the requests, data_o equals data_i[gnt_idx_o*DATA_W +: DATA_W] of the winner.
- R6: A cycle without a grant leaves the priority state unchanged.
- R7: The block enters the locked state at a clock edge where lock_i=1 and either a grant was issued or the block was already locked. While locked, gnt_vld_o=1 and the grant, index and data all belong to the held input, whatever req_i is. The locked state ends at the first edge where lock_i=0.
- R8: The priority state does not change while the block is locked. After the lock is released, arbitration resumes with the input just above the held one.
- R9: Reset is synchronous and active-low. It sets every priority bit and clears the locked state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | N_IN | Request bit per input |
| lock_i | input | 1 | Keep the current connection through the next cycle |
| data_i | input | N_IN*DATA_W | Data words; input i occupies bits [i*DATA_W +: DATA_W] |
| gnt_vld_o | output | 1 | A grant is issued this cycle |
| gnt_oh_o | output | N_IN | One-hot grant |
| gnt_idx_o | output | $clog2(N_IN) | Binary index of the granted input |
| data_o | output | DATA_W | Data word of the granted input, zero with no grant |

## Verification
Several properties are checked on every cycle:
- the grant is one-hot, agrees with the index and belongs to a requester;
- the output word is the winner's word;
- the root symbol reports the high-priority class whenever any high-priority requester exists;
- the priority mask stays still through idle and locked cycles;
- a locked grant repeats the previous cycle's index.

The bench's scenarios are needed for two things:
- showing that the order is truly round-robin over a long sequence, which it does by comparing against a cyclic-search model;
- showing that the lock is entered, held through a dropped request and released at the right cycles.

// File: rtl/rrmx_pkg.sv
`timescale 1ns/1ps
// Shared types for the max-tree arbiter.
// Assumes: symbols are compared as 2-bit unsigned numbers.
package rrmx_pkg;
    // Arbitration symbol: [1] request, [0] priority
    typedef logic [1:0] sym_t;

    // Builds a symbol from a request bit and a priority bit
    function automatic sym_t make_sym(input logic req, input logic pri);
        return {req, pri};
    endfunction
endpackage

// File: rtl/rrmx_node.sv
`timescale 1ns/1ps
// One maximum-selection node of the arbitration tree.
// Forwards the larger symbol and its data word. On equal symbols the right
// child (lower input indices) wins. The flag is 1 only when the left child won.
// Assumes: the left child covers the higher input indices.
module rrmx_node
    import rrmx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  sym_t              l_sym,
    input  sym_t              r_sym,
    input  logic [DATA_W-1:0] l_data,
    input  logic [DATA_W-1:0] r_data,
    output sym_t              o_sym,
    output logic [DATA_W-1:0] o_data,
    output logic              o_flag
);
    // Compare, steer symbol and data with the same flag
    always_comb begin
        o_flag = (l_sym > r_sym);
        o_sym  = o_flag ? l_sym  : r_sym;
        o_data = o_flag ? l_data : r_data;
    end
endmodule

// File: rtl/rrmx_tree.sv
`timescale 1ns/1ps
// Heap-ordered tree of rrmx_node. Node n has children 2n+1 (left) and 2n (right).
// Leaves P..2P-1 hold inputs 0..P-1, and padding leaves carry a zero symbol.
// The winner index is read by following the direction flags from the root.
// Assumes: P is a power of two equal to 2**LEVELS, with LEVELS >= 1.
module rrmx_tree
    import rrmx_pkg::*;
#(
    parameter int N      = 8,
    parameter int DATA_W = 16,
    parameter int LEVELS = 3,
    parameter int P      = 8
) (
    input  logic [2*N-1:0]      sym_i,
    input  logic [N*DATA_W-1:0] data_i,
    output sym_t                root_sym_o,
    output logic [DATA_W-1:0]   root_data_o,
    output logic [LEVELS-1:0]   win_idx_o
);
    sym_t              h_sym  [1:2*P-1];
    logic [DATA_W-1:0] h_data [1:2*P-1];
    logic [P-2:0]      flags;

    // Leaf loading with zero padding above N
    for (genvar j = 0; j < P; j++) begin : g_leaf
        if (j < N) begin : g_real
            assign h_sym[P+j]  = sym_i[2*j +: 2];
            assign h_data[P+j] = data_i[j*DATA_W +: DATA_W];
        end else begin : g_pad
            assign h_sym[P+j]  = '0;
            assign h_data[P+j] = '0;
        end
    end

    // Node levels: lv is the index bit that the level decides
    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
        for (genvar k = 0; k < (P >> (lv + 1)); k++) begin : g_nd
            localparam int NID = (P >> (lv + 1)) + k;
            rrmx_node #(.DATA_W(DATA_W)) i_node (
                .l_sym  (h_sym[2*NID+1]),
                .r_sym  (h_sym[2*NID]),
                .l_data (h_data[2*NID+1]),
                .r_data (h_data[2*NID]),
                .o_sym  (h_sym[NID]),
                .o_data (h_data[NID]),
                .o_flag (flags[NID-1])
            );
        end
    end

    assign root_sym_o  = h_sym[1];
    assign root_data_o = h_data[1];

    // Walk the flag path from root to leaf to form the binary index
    always_comb begin
        int n;
        n = 1;
        win_idx_o = '0;
        for (int d = 0; d < LEVELS; d++) begin
            win_idx_o[LEVELS-1-d] = flags[n-1];
            n = 2*n + int'(flags[n-1]);
        end
    end
endmodule

// File: rtl/rrmx_prio.sv
`timescale 1ns/1ps
// Priority and lock state. The mask bit for input i is set when i lies above
// the last unlocked grant. It is loaded only on grants made while unlocked.
// Assumes: gnt_idx_i is meaningful only while gnt_vld_i is high.
module rrmx_prio #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gnt_vld_i,
    input  logic [IW-1:0] gnt_idx_i,
    input  logic          lock_i,
    output logic [N-1:0]  mask_o,
    output logic          locked_o,
    output logic [IW-1:0] held_idx_o
);
    logic [N-1:0] mask_nxt;

    // Thermometer mask of inputs above the current grant
    always_comb begin
        for (int i = 0; i < N; i++) mask_nxt[i] = (i > int'(gnt_idx_i));
    end

    // State update: lock tracking and priority reload on free grants
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o     <= '1;
            locked_o   <= 1'b0;
            held_idx_o <= '0;
        end else begin
            locked_o <= lock_i && (locked_o || gnt_vld_i);
            if (gnt_vld_i && !locked_o) begin
                mask_o     <= mask_nxt;
                held_idx_o <= gnt_idx_i;
            end
        end
    end
endmodule

// File: rtl/rrmx_arb.sv
`timescale 1ns/1ps
// Round-robin arbiter merged with its data multiplexer. Symbols {req, prio}
// feed a rightmost-maximum tree, and the tree's flags switch data and form the
// index. While locked, only the held input presents a request.
// Assumes: N_IN >= 2; all outputs are combinational from inputs and state.
module rrmx_arb
    import rrmx_pkg::*;
#(
    parameter int N_IN   = 8,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_IN-1:0]          req_i,
    input  logic                     lock_i,
    input  logic [N_IN*DATA_W-1:0]   data_i,
    output logic                     gnt_vld_o,
    output logic [N_IN-1:0]          gnt_oh_o,
    output logic [$clog2(N_IN)-1:0]  gnt_idx_o,
    output logic [DATA_W-1:0]        data_o
);
    localparam int IDX_W = $clog2(N_IN);
    localparam int P     = 1 << IDX_W;

    logic [N_IN-1:0]   mask;
    logic              locked;
    logic [IDX_W-1:0]  held_idx;
    logic [N_IN-1:0]   eff_req;
    logic [2*N_IN-1:0] syms;
    sym_t              root_sym;
    logic [DATA_W-1:0] root_data;
    logic [IDX_W-1:0]  tree_idx;

    // Request source: the held input alone while locked
    always_comb begin
        eff_req = locked ? (N_IN'(1) << held_idx) : req_i;
        for (int i = 0; i < N_IN; i++) syms[2*i +: 2] = make_sym(eff_req[i], mask[i]);
    end

    rrmx_tree #(.N(N_IN), .DATA_W(DATA_W), .LEVELS(IDX_W), .P(P)) i_tree (
        .sym_i       (syms),
        .data_i      (data_i),
        .root_sym_o  (root_sym),
        .root_data_o (root_data),
        .win_idx_o   (tree_idx)
    );

    rrmx_prio #(.N(N_IN), .IW(IDX_W)) i_prio (
        .clk        (clk),
        .rst_n      (rst_n),
        .gnt_vld_i  (gnt_vld_o),
        .gnt_idx_i  (gnt_idx_o),
        .lock_i     (lock_i),
        .mask_o     (mask),
        .locked_o   (locked),
        .held_idx_o (held_idx)
    );

    // Output forming: all outputs are zero when no grant is issued
    always_comb begin
        gnt_vld_o = root_sym[1];
        gnt_idx_o = gnt_vld_o ? tree_idx  : '0;
        data_o    = gnt_vld_o ? root_data : '0;
        for (int i = 0; i < N_IN; i++) gnt_oh_o[i] = gnt_vld_o && (tree_idx == IDX_W'(i));
    end

    AST_GNT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld_o && !locked) |-> req_i[gnt_idx_o]);                          // R1
    AST_IDLE_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && req_i == '0) |-> (!gnt_vld_o && gnt_oh_o == '0));          // R1
    AST_HIGH_CLASS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && (|(req_i & mask))) |-> (root_sym == 2'b11));               // R3
    AST_ONEHOT_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_oh_o) && (gnt_oh_o[gnt_idx_o] == gnt_vld_o));             // R4
    AST_DATA_OF_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld_o |-> (data_o == data_i[gnt_idx_o*DATA_W +: DATA_W]));         // R5
    AST_IDLE_PRIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_vld_o |=> $stable(mask));                                         // R6
    AST_LOCK_KEEPS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (gnt_vld_o && gnt_idx_o == $past(gnt_idx_o)));              // R7
    AST_LOCK_PRIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(mask));                                             // R8
endmodule

// File: tb/test_rrmx_arb.sv
`timescale 1ns/1ps
module test_rrmx_arb;
    localparam int N  = 8;
    localparam int W  = 16;
    localparam int IW = $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req = '0;
    logic            lock = 1'b0;
    logic [N*W-1:0]  data = '0;
    logic            gnt_vld;
    logic [N-1:0]    gnt_oh;
    logic [IW-1:0]   gnt_idx;
    logic [W-1:0]    dout;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // Reference state: cyclic-search model
    int last_g = N - 1;
    bit locked_m = 0;
    int held_m = 0;

    always #10 clk = ~clk;

    rrmx_arb #(.N_IN(N), .DATA_W(W)) i_rrmx_arb (
        .clk(clk), .rst_n(rst_n), .req_i(req), .lock_i(lock), .data_i(data),
        .gnt_vld_o(gnt_vld), .gnt_oh_o(gnt_oh), .gnt_idx_o(gnt_idx), .data_o(dout)
    );

    function automatic int cyclic_pick(input logic [N-1:0] r, input int last);
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (last + k) % N;
            if (r[c]) return c;
        end
        return -1;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input logic [N-1:0] r, input logic lk, input string tag);
        int e_idx;
        bit e_vld;
        logic [W-1:0] e_data;
        logic [N-1:0] e_oh;
        @(negedge clk);
        req  = r;
        lock = lk;
        for (int i = 0; i < N; i++) data[i*W +: W] = W'($urandom);
        #5;
        if (locked_m) begin
            e_vld = 1; e_idx = held_m;
        end else begin
            e_idx = cyclic_pick(r, last_g);
            e_vld = (e_idx >= 0);
            if (!e_vld) e_idx = 0;
        end
        e_data = e_vld ? data[e_idx*W +: W] : '0;
        e_oh   = e_vld ? (N'(1) << e_idx) : '0;
        vectors++;
        check({tag, " valid"}, 64'(gnt_vld), 64'(e_vld));
        check({tag, " R4 index"}, 64'(gnt_idx), 64'(e_idx));
        check({tag, " R4 onehot"}, 64'(gnt_oh), 64'(e_oh));
        check({tag, " R5 data"}, 64'(dout), 64'(e_data));
        // State advances at the next rising edge
        if (!locked_m && e_vld) begin
            last_g = e_idx;
            held_m = e_idx;
        end
        locked_m = lk && (locked_m || e_vld);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9 / R1: reset state, no requests
        run_vec('0, 1'b0, "R9 R1 reset-idle");
        // R2: first grant to lowest requester
        run_vec(8'b1010_0100, 1'b0, "R2 first");
        // R3: rotation with all requesting
        for (int i = 0; i < 10; i++) run_vec('1, 1'b0, "R3 all");
        // R3: wrap with two requesters
        run_vec(8'b1000_0010, 1'b0, "R3 wrap-a");
        run_vec(8'b1000_0010, 1'b0, "R3 wrap-b");
        run_vec(8'b1000_0010, 1'b0, "R3 wrap-c");
        // R6: idle cycles keep priority
        run_vec('0, 1'b0, "R6 idle");
        run_vec('0, 1'b0, "R6 idle");
        run_vec(8'b1000_0010, 1'b0, "R6 after-idle");
        // R7: lock, held input drops its request
        run_vec(8'b0001_0001, 1'b1, "R7 head");
        run_vec(8'b1111_1110, 1'b1, "R7 body");
        run_vec(8'b0000_0000, 1'b0, "R7 tail");
        // R8: resume after released lock
        run_vec('1, 1'b0, "R8 resume");
        run_vec('1, 1'b0, "R8 resume2");
        // Random phase covering R1..R8
        for (int n = 0; n < 4000; n++) begin
            logic [N-1:0] r;
            case ($urandom % 4)
                0: r = N'($urandom & $urandom);
                1: r = N'($urandom | $urandom);
                2: r = N'(1) << ($urandom % N);
                default: r = ($urandom % 3 == 0) ? '0 : N'($urandom);
            endcase
            run_vec(r, ($urandom % 4 == 0), "R3 R7 random");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule